// File: doc/BRIEF.md
# Adaptive ADPCM Nibble Decoder

This block turns a stream of 4-bit adaptive delta codes into signed 16-bit PCM samples. It keeps two values. One is a predictor, the running sample estimate. The other is an adaptive step size. Each code moves the predictor by an odd multiple of one eighth of the step, and it then scales the step up or down by a factor picked from a small table. Both values saturate.

A 16-bit fractional phase sets the output rate relative to the code rate. On every output tick the programmed rate increment is added to the phase. Each whole unit that carries out of the fraction pulls one code from the source, so a tick can consume zero, one or several codes. Once the codes for a tick have been consumed, the block outputs a value interpolated linearly between the predictor before the last code and the current predictor, weighted by the fraction that remains. That value is then scaled by an 8-bit volume.

Codes arrive through a request/valid handshake. When the source has no code ready, the decoder waits and the output keeps its last value. A start pulse restarts decoding from a clean state at any time. Fetching and addressing the codes are handled outside this block.

Top module: `adpcm_nibble_decoder`

## Requirements
- R1: For each accepted code c, the predictor changes by trunc((2*c[2:0]+1) * step / 8). The change is added when c[3] is 0 and subtracted when c[3] is 1.
- R2: After every update the predictor is clamped to the range -32768 to 32767.
- R3: After every update the step becomes trunc(step * f / 64). The factor f is 57 for c[2:0] from 0 to 3, and 77, 102, 128 or 153 for c[2:0] equal to 4, 5, 6 or 7. Bit c[3] does not affect the step.
- R4: The step is clamped to the range 127 to 24576. It is 127 after reset and after every start pulse.
- R5: A start pulse sets the predictor, the previous predictor, the phase and sample_o to zero. sample_o reads 0 in the cycle after the pulse.
- R6: An accepted tick adds rate_i to the 16-bit phase. The tick consumes exactly floor((phase + rate_i) / 65536) codes, and the low 16 bits of the sum become the new phase.
- R7: The previous predictor takes the value of the predictor just before each code is applied.
- R8: After the codes of a tick are consumed, sample_valid_o pulses high for exactly one cycle. Together with the pulse, sample_o = floor(floor((prev*(65536-phase) + pred*phase) / 65536) * vol_i / 256).
- R9: While nib_req_o is high and nib_valid_i is low, the decoder stalls. nib_req_o stays high and sample_o does not change.
- R10: Before the first start pulse, tick_i has no effect: no code is requested and no sample is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; clears the decoder state and begins decoding |
| tick_i | input | 1 | Output-rate tick; accepted only while the decoder is waiting for a tick |
| rate_i | input | RATE_W (18) | Phase increment per tick; the low 16 bits are the fraction |
| vol_i | input | 8 | Linear output volume, where 256 would equal unity gain |
| nib_req_o | output | 1 | The decoder needs a code |
| nib_valid_i | input | 1 | A code is present on nib_i |
| nib_i | input | 4 | Code; bit 3 is the sign, bits 2:0 the magnitude |
| sample_o | output | 16 | Signed output sample |
| sample_valid_o | output | 1 | One-cycle pulse marking a new sample |

## Verification
Some properties are checked by assertions on every cycle. The step always lies inside its clamp range. A positive code never lowers the predictor. A code with a small magnitude never raises the step. The output holds during a stall, the valid strobe lasts one cycle, and a start pulse leaves the output at zero.

The exact arithmetic can only be shown by the bench's scenarios. These cover the rounding of the predictor and step updates, the saturation points, the number of codes each tick consumes, and the interpolated, volume-scaled value. The bench sweeps all sixteen codes from several step levels and drives both rails into saturation. It also varies the rate between fractional and multi-code steps, and the volume between zero and near unity. It compares every sample against an arithmetic model.

// File: rtl/adpcm_dec_pkg.sv
package adpcm_dec_pkg;
  localparam int PRED_W   = 16;
  localparam int STEP_W   = 15;
  localparam int FRAC_W   = 16;
  localparam int VOL_W    = 8;
  localparam int STEP_MIN = 127;
  localparam int STEP_MAX = 24576;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DEC,
    ST_OUT
  } dec_state_e;

  // step growth factor, scaled by 64; sign bit of the code is not used
  function automatic logic [7:0] step_factor(input logic [2:0] mag);
    case (mag)
      3'd4:    step_factor = 8'd77;
      3'd5:    step_factor = 8'd102;
      3'd6:    step_factor = 8'd128;
      3'd7:    step_factor = 8'd153;
      default: step_factor = 8'd57;
    endcase
  endfunction
endpackage

// File: rtl/adpcm_dec_phase.sv
module adpcm_dec_phase
  import adpcm_dec_pkg::*;
#(
  parameter int RATE_W = 18,
  localparam int CNT_W = RATE_W + 1 - FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              adv_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic [CNT_W-1:0]  whole_o
);
  logic [FRAC_W-1:0] frac_q;
  logic [RATE_W:0]   sum;

  assign sum     = {{(RATE_W + 1 - FRAC_W){1'b0}}, frac_q} + {1'b0, rate_i};
  assign whole_o = CNT_W'(sum >> FRAC_W);
  assign frac_o  = frac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      frac_q <= '0;
    else if (clear_i) frac_q <= '0;
    else if (adv_i)   frac_q <= FRAC_W'(sum);
  end
endmodule

// File: rtl/adpcm_dec_core.sv
module adpcm_dec_core
  import adpcm_dec_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     upd_i,
  input  logic [3:0]               code_i,
  output logic signed [PRED_W-1:0] pred_o,
  output logic signed [PRED_W-1:0] prev_o,
  output logic [STEP_W-1:0]        step_o
);
  localparam int SUM_W = PRED_W + 2;
  localparam int SP_W  = STEP_W + 8;
  localparam logic signed [SUM_W-1:0] P_MAX = SUM_W'((2 ** (PRED_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] P_MIN = -SUM_W'(2 ** (PRED_W - 1));

  logic signed [PRED_W-1:0] pred_q, prev_q;
  logic [STEP_W-1:0]        step_q;

  logic [STEP_W+3:0]        mag_prod;
  logic [STEP_W:0]          mag;
  logic signed [SUM_W-1:0]  pred_ext, mag_ext, pred_sum;
  logic signed [PRED_W-1:0] pred_nxt;
  logic [SP_W-1:0]          step_prod;
  logic [STEP_W+1:0]        step_raw;
  logic [STEP_W-1:0]        step_nxt;

  // predictor move: odd multiple of step/8, sign from code bit 3
  assign mag_prod = {{STEP_W{1'b0}}, code_i[2:0], 1'b1} * {4'b0000, step_q};
  assign mag      = (STEP_W + 1)'(mag_prod >> 3);
  assign pred_ext = {{2{pred_q[PRED_W-1]}}, pred_q};
  assign mag_ext  = {2'b00, mag};
  assign pred_sum = code_i[3] ? pred_ext - mag_ext : pred_ext + mag_ext;

  always_comb begin
    if (pred_sum > P_MAX)      pred_nxt = PRED_W'(P_MAX);
    else if (pred_sum < P_MIN) pred_nxt = PRED_W'(P_MIN);
    else                       pred_nxt = PRED_W'(pred_sum);
  end

  assign step_prod = {8'h00, step_q} * {{STEP_W{1'b0}}, step_factor(code_i[2:0])};
  assign step_raw  = (STEP_W + 2)'(step_prod >> 6);

  always_comb begin
    if (step_raw > (STEP_W + 2)'(STEP_MAX))      step_nxt = STEP_W'(STEP_MAX);
    else if (step_raw < (STEP_W + 2)'(STEP_MIN)) step_nxt = STEP_W'(STEP_MIN);
    else                                         step_nxt = STEP_W'(step_raw);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_q <= '0;
      prev_q <= '0;
      step_q <= STEP_W'(STEP_MIN);
    end else if (clear_i) begin
      pred_q <= '0;
      prev_q <= '0;
      step_q <= STEP_W'(STEP_MIN);
    end else if (upd_i) begin
      prev_q <= pred_q;
      pred_q <= pred_nxt;
      step_q <= step_nxt;
    end
  end

  assign pred_o = pred_q;
  assign prev_o = prev_q;
  assign step_o = step_q;

  assert_step_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q >= STEP_W'(STEP_MIN)) && (step_q <= STEP_W'(STEP_MAX)));

  assert_pos_code_rises_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clear_i && !code_i[3]) |=> (pred_q >= $past(pred_q)));

  assert_small_code_shrinks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clear_i && !code_i[2]) |=> (step_q <= $past(step_q)));
endmodule

// File: rtl/adpcm_dec_mix.sv
module adpcm_dec_mix
  import adpcm_dec_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     load_i,
  input  logic signed [PRED_W-1:0] prev_i,
  input  logic signed [PRED_W-1:0] cur_i,
  input  logic [FRAC_W-1:0]        frac_i,
  input  logic [VOL_W-1:0]         vol_i,
  output logic signed [PRED_W-1:0] sample_o
);
  localparam int ACC_W = PRED_W + FRAC_W + 3;
  localparam int INT_W = PRED_W + 2;
  localparam int SCL_W = INT_W + VOL_W + 2;

  logic [FRAC_W:0]         w_prev;
  logic signed [ACC_W-1:0] prev_x, cur_x, wp_x, wc_x, blend;
  logic signed [INT_W-1:0] interp;
  logic signed [SCL_W-1:0] interp_x, vol_x, scaled;
  logic signed [PRED_W-1:0] sample_q;

  assign w_prev   = (FRAC_W + 1)'(2 ** FRAC_W) - {1'b0, frac_i};
  assign prev_x   = {{(ACC_W - PRED_W){prev_i[PRED_W-1]}}, prev_i};
  assign cur_x    = {{(ACC_W - PRED_W){cur_i[PRED_W-1]}}, cur_i};
  assign wp_x     = {{(ACC_W - FRAC_W - 1){1'b0}}, w_prev};
  assign wc_x     = {{(ACC_W - FRAC_W){1'b0}}, frac_i};
  assign blend    = prev_x * wp_x + cur_x * wc_x;
  // arithmetic shift floors the weighted sum
  assign interp   = INT_W'(blend >>> FRAC_W);
  assign interp_x = {{(SCL_W - INT_W){interp[INT_W-1]}}, interp};
  assign vol_x    = {{(SCL_W - VOL_W){1'b0}}, vol_i};
  assign scaled   = interp_x * vol_x;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sample_q <= '0;
    else if (clear_i) sample_q <= '0;
    else if (load_i)  sample_q <= PRED_W'(scaled >>> VOL_W);
  end

  assign sample_o = sample_q;
endmodule

// File: rtl/adpcm_nibble_decoder.sv
module adpcm_nibble_decoder
  import adpcm_dec_pkg::*;
#(
  parameter int RATE_W = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     tick_i,
  input  logic [RATE_W-1:0]        rate_i,
  input  logic [VOL_W-1:0]         vol_i,
  output logic                     nib_req_o,
  input  logic                     nib_valid_i,
  input  logic [3:0]               nib_i,
  output logic signed [PRED_W-1:0] sample_o,
  output logic                     sample_valid_o
);
  localparam int CNT_W = RATE_W + 1 - FRAC_W;

  dec_state_e               state_q;
  logic [CNT_W-1:0]         remain_q;
  logic                     valid_q;
  logic                     tick_acc, upd, load;
  logic [FRAC_W-1:0]        frac;
  logic [CNT_W-1:0]         whole;
  logic signed [PRED_W-1:0] pred, prev;
  logic [STEP_W-1:0]        step_unused;

  assign tick_acc = (state_q == ST_RUN) && tick_i && !start_i;
  assign upd      = (state_q == ST_DEC) && nib_valid_i && !start_i;
  assign load     = (state_q == ST_OUT) && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= load;
      if (start_i) begin
        state_q  <= ST_RUN;
        remain_q <= '0;
      end else begin
        case (state_q)
          ST_RUN: if (tick_i) begin
            remain_q <= whole;
            state_q  <= (whole == '0) ? ST_OUT : ST_DEC;
          end
          ST_DEC: if (nib_valid_i) begin
            remain_q <= remain_q - 1'b1;
            if (remain_q == CNT_W'(1)) state_q <= ST_OUT;
          end
          ST_OUT:  state_q <= ST_RUN;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  adpcm_dec_phase #(.RATE_W(RATE_W)) phase_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(start_i),
    .adv_i  (tick_acc),
    .rate_i (rate_i),
    .frac_o (frac),
    .whole_o(whole)
  );

  adpcm_dec_core core_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(start_i),
    .upd_i  (upd),
    .code_i (nib_i),
    .pred_o (pred),
    .prev_o (prev),
    .step_o (step_unused)
  );

  adpcm_dec_mix mix_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i),
    .load_i  (load),
    .prev_i  (prev),
    .cur_i   (pred),
    .frac_i  (frac),
    .vol_i   (vol_i),
    .sample_o(sample_o)
  );

  assign nib_req_o      = (state_q == ST_DEC);
  assign sample_valid_o = valid_q;

  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |=> !sample_valid_o);

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_req_o && !nib_valid_i && !start_i) |=> ($stable(sample_o) && nib_req_o));

  assert_start_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ((sample_o == '0) && !sample_valid_o));

  assert_dec_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_req_o |-> (remain_q != '0));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!nib_req_o && !sample_valid_o));
endmodule

// File: tb/adpcm_nibble_decoder_tb.sv
`timescale 1ns/1ps
module adpcm_nibble_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        tick_i = 1'b0;
  logic [17:0] rate_i = '0;
  logic [7:0]  vol_i = '0;
  logic        nib_req_o;
  logic        nib_valid_i = 1'b0;
  logic [3:0]  nib_i = '0;
  logic signed [15:0] sample_o;
  logic        sample_valid_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_pred = 0, m_prev = 0, m_step = 127, m_phase = 0, last_out = 0;
  int code_q[$];

  always #2.5 clk = ~clk;

  adpcm_nibble_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .tick_i(tick_i),
    .rate_i(rate_i), .vol_i(vol_i), .nib_req_o(nib_req_o),
    .nib_valid_i(nib_valid_i), .nib_i(nib_i), .sample_o(sample_o),
    .sample_valid_o(sample_valid_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fac_of(input int c);
    case (c & 7)
      4: return 77;
      5: return 102;
      6: return 128;
      7: return 153;
      default: return 57;
    endcase
  endfunction

  function automatic void model_code(input int c);
    int mag;
    mag = (((c & 7) * 2 + 1) * m_step) / 8;
    m_prev = m_pred;
    m_pred = (c & 8) ? m_pred - mag : m_pred + mag;
    if (m_pred > 32767) m_pred = 32767;
    if (m_pred < -32768) m_pred = -32768;
    m_step = (m_step * fac_of(c)) / 64;
    if (m_step > 24576) m_step = 24576;
    if (m_step < 127) m_step = 127;
  endfunction

  function automatic int model_out(input int vol);
    longint b, s;
    b = longint'(m_prev) * (65536 - m_phase) + longint'(m_pred) * m_phase;
    b = b >>> 16;
    s = (b * vol) >>> 8;
    return int'(s);
  endfunction

  task automatic do_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    m_pred = 0; m_prev = 0; m_step = 127; m_phase = 0; last_out = 0;
    code_q.delete();
  endtask

  task automatic run_tick(input int rate, input int vol, input int stall, input string req);
    int sum, need, got, waitc, c, exp;
    bit hold_ok;
    vol_i = 8'(vol);
    @(negedge clk); tick_i = 1'b1; rate_i = 18'(rate);
    sum = m_phase + rate; need = sum >>> 16; m_phase = sum & 'hFFFF;
    @(negedge clk); tick_i = 1'b0;
    hold_ok = 1'b1;
    for (int s = 0; s < stall; s++) begin
      if (!nib_req_o || int'(sample_o) != last_out) hold_ok = 1'b0;
      @(negedge clk);
    end
    if (stall > 0) check(hold_ok, "R9 stall hold", int'(sample_o), last_out);
    got = 0; waitc = 0;
    while (!sample_valid_o && waitc < 64) begin
      if (nib_req_o) begin
        c = (code_q.size() > 0) ? code_q.pop_front() : 0;
        nib_i = 4'(c); nib_valid_i = 1'b1; model_code(c); got++;
      end else nib_valid_i = 1'b0;
      @(negedge clk); waitc++;
    end
    nib_valid_i = 1'b0;
    exp = model_out(vol);
    check(sample_valid_o, {req, " valid"}, int'(sample_valid_o), 1);
    check(got == need, "R6 codes per tick", got, need);
    check(int'(sample_o) == exp, req, int'(sample_o), exp);
    last_out = exp;
    @(negedge clk);
    check(!sample_valid_o, "R8 single pulse", int'(sample_valid_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit idle_ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sample_o == 0 && !sample_valid_o && !nib_req_o, "R5 reset state", int'(sample_o), 0);

    // R10: tick before any start
    @(negedge clk); tick_i = 1'b1; rate_i = 18'h10000;
    @(negedge clk); tick_i = 1'b0;
    idle_ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (nib_req_o || sample_valid_o) idle_ok = 1'b0;
      @(negedge clk);
    end
    check(idle_ok, "R10 idle tick ignored", int'(nib_req_o), 0);

    // sweep all codes from several step levels, one code per tick
    for (int c = 0; c < 16; c++) begin
      for (int k = 0; k < 3; k++) begin
        int pre;
        pre = (k == 0) ? 0 : (k == 1) ? 2 : 9;
        do_start();
        for (int p = 0; p < pre; p++) begin
          code_q.push_back((p % 2) ? 14 : 6);
          run_tick('h10000, 255, 0, "R1 R3 R7 prefix");
        end
        code_q.push_back(c);
        run_tick('h10000, 255, 0, "R1 R3 code sweep");
      end
    end

    // positive and negative saturation, step ceiling
    do_start();
    for (int i = 0; i < 14; i++) begin code_q.push_back(7); run_tick('h10000, 255, 0, "R2 R4 high rail"); end
    for (int i = 0; i < 14; i++) begin code_q.push_back(15); run_tick('h10000, 255, 0, "R2 R4 low rail"); end
    // step floor: small codes repeatedly
    for (int i = 0; i < 30; i++) begin code_q.push_back((i % 2) ? 8 : 0); run_tick('h10000, 255, 0, "R3 R4 step floor"); end

    // fractional and multi-code rates with interpolation
    do_start();
    for (int i = 0; i < 24; i++) begin
      for (int j = 0; j < 3; j++) code_q.push_back((i * 5 + j * 3 + 1) % 16);
      run_tick('h28000, 128, 0, "R6 R7 R8 multi code");
    end
    do_start();
    for (int i = 0; i < 24; i++) begin
      code_q.push_back((i * 7 + 3) % 16);
      run_tick('h6000, 200, 0, "R6 R8 fractional rate");
    end
    do_start();
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 4; j++) code_q.push_back((i + j * 6) % 16);
      run_tick('h3FFFF, 255, 0, "R6 R8 max rate");
    end

    // volume zero
    for (int i = 0; i < 4; i++) begin code_q.push_back(5); run_tick('h10000, 0, 0, "R8 zero volume"); end

    // stall with the source empty
    do_start();
    for (int i = 0; i < 4; i++) begin
      code_q.push_back(4 + i);
      run_tick('h10000, 255, 0, "R8 pre stall");
    end
    for (int i = 0; i < 3; i++) begin
      code_q.push_back(9 + i);
      run_tick('h10000, 255, 5 + i, "R9 after stall");
    end

    // restart mid-stream clears output and phase
    code_q.push_back(7);
    run_tick('h8000, 255, 0, "R8 before restart");
    do_start();
    check(sample_o == 0, "R5 start clears output", int'(sample_o), 0);
    run_tick('h0, 255, 0, "R5 zero after start");
    code_q.push_back(3);
    run_tick('h8000, 255, 0, "R5 R6 phase cleared");
    code_q.push_back(3);
    run_tick('h8000, 255, 0, "R5 R6 phase carry");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule